// File: doc/BRIEF.md
# Shared-Pin Digital/Analog Port Controller

This block controls a bank of general-purpose pins. The lower pins are digital only. Each upper pin is shared with one analog output channel. For every pin, the block decides whether the pin drives a digital level, is handed to its analog channel, or floats as an input. It does this from two registers that decoded serial commands write:

- a pin-direction register, in which a 1 means "digital output";
- an output-level register.

It also takes a snapshot of the pin inputs, which the serial shift register reads back. Pins that are not acting as inputs read as zero in that snapshot.

The command decoder outside this block supplies the following:

- single-cycle strobes for each command;
- a payload taken from the upper bits of the serial word. Payload bit `i` belongs to pin `i`.
- a strobe for the chip-select falling edge.

The analog channel controller supplies one analog-mode flag for each shared pin. A set direction bit always overrides analog mode. The analog flag can still change while the pin is a digital output. When the direction bit is cleared, the pin goes back to whatever the flag then says.

Top module: `pin_expander_top`

## Requirements
- R1: While reset is asserted, and after it is released with no command given, `driveEn` is all zero, `captureWord` is zero and `captureLoad` is low. With all analog flags clear, `anaSel` is also zero.
- R2: A `cmdParWrite` strobe loads `payload` into the output-level register, with payload bit i belonging to pin i. On the next cycle, every pin whose direction bit is 1 shows that bit on `driveVal`.
- R3: A `cmdStatusWrite` strobe loads `payload` into the direction register, with payload bit i belonging to pin i. From the next cycle, `driveEn` equals that value.
- R4: A pin whose direction bit is 1 never has `anaSel` asserted, whatever its analog flag says. `driveEn` and `anaSel` are never both high for the same pin.
- R5: For shared pin `DIGITAL_ONLY+j`, `anaSel` equals `anaMode[j]` AND NOT the direction bit, with no added latency. A flag change made while the direction bit is 1 therefore takes effect as soon as that bit is cleared.
- R6: Pins 0 to `DIGITAL_ONLY-1` never assert `anaSel`.
- R7: `cmdCaptureArm` arms a capture. The next `csFall` strobe then loads `captureWord` from the pin inputs and raises `captureLoad` for exactly one cycle after the strobe's edge. The inputs pass through a `SYNC_STAGES`-flop synchroniser, so the word reflects `pinIn` as it was `SYNC_STAGES` edges before the capturing edge.
- R8: In a captured word, a bit reads as 0 if its pin had its direction bit set, or had `anaSel` asserted, in the cycle of the `csFall` strobe.
- R9: A `csFall` strobe with no armed capture leaves `captureWord` unchanged and `captureLoad` low. One arm serves only one `csFall`.
- R10: A `cmdParWrite` or `cmdStatusWrite` strobe that arrives after an arm and before the `csFall` strobe cancels the armed capture.
- R11: Reset does not clear the output-level register. A value written before a reset reappears on `driveVal` once the direction bits are set again afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdParWrite | input | 1 | Strobe: load the output-level register from payload |
| cmdStatusWrite | input | 1 | Strobe: load the direction register from payload |
| cmdCaptureArm | input | 1 | Strobe: arm a pin snapshot for the next chip-select fall |
| csFall | input | 1 | Strobe: chip-select falling edge seen |
| payload | input | PIN_COUNT | Command payload, bit i belongs to pin i |
| anaMode | input | PIN_COUNT-DIGITAL_ONLY | Analog-mode flag; bit j belongs to pin DIGITAL_ONLY+j |
| pinIn | input | PIN_COUNT | Raw pin input levels |
| driveEn | output | PIN_COUNT | Per-pin digital drive enable |
| driveVal | output | PIN_COUNT | Per-pin digital drive level |
| anaSel | output | PIN_COUNT | Per-pin hand-over to analog channel |
| captureWord | output | PIN_COUNT | Last pin snapshot, non-input pins zero |
| captureLoad | output | 1 | One-cycle pulse when captureWord is updated |

## Verification
The bench builds the block with 12 pins, 4 of them digital only, and a two-flop synchroniser. This mix puts both pin variants side by side, so the digital-only pins can be seen to ignore analog mode while the shared ones hand over and return.

The two-stage synchroniser is short enough that a single directed case can cover the synchroniser latency. In that case, the input changes on the very cycle of the capture strobe, and the snapshot still holds the older value. The 8-bit analog flag vector lets masked captures mix three kinds of pin in one word: digital outputs, analog pins and plain inputs.

// File: rtl/pin_expander_pkg.sv
package pin_expander_pkg;

  // Strobes passed from control to datapath, valid for one cycle.
  typedef struct packed {
    logic loadOut;     // take payload into the output-level register
    logic loadStatus;  // take payload into the direction register
    logic capture;     // snapshot the synchronised pins
  } ctlStrobes_t;

endpackage

// File: rtl/pin_expander_sync.sv
module pin_expander_sync #(
  parameter int WIDTH  = 12,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chain <= '0;
    end else begin
      chain[0] <= din;
      for (int s = 1; s < STAGES; s++) begin
        chain[s] <= chain[s-1];
      end
    end
  end

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/pin_expander_ctrl.sv
module pin_expander_ctrl
  import pin_expander_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdParWrite,
  input  logic        cmdStatusWrite,
  input  logic        cmdCaptureArm,
  input  logic        csFall,
  output ctlStrobes_t strobes
);

  logic armedQ;
  logic armedNext;

  // A new arm wins; a chip-select fall or any other write consumes it.
  always_comb begin
    armedNext = armedQ;
    if (cmdCaptureArm) begin
      armedNext = 1'b1;
    end else if (csFall || cmdParWrite || cmdStatusWrite) begin
      armedNext = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armedQ <= 1'b0;
    end else begin
      armedQ <= armedNext;
    end
  end

  always_comb begin
    strobes.loadOut    = cmdParWrite;
    strobes.loadStatus = cmdStatusWrite;
    strobes.capture    = csFall & armedQ;
  end

endmodule

// File: rtl/pin_expander_dp.sv
module pin_expander_dp
  import pin_expander_pkg::*;
#(
  parameter int PIN_COUNT    = 12,
  parameter int DIGITAL_ONLY = 4,
  localparam int SHARED      = PIN_COUNT - DIGITAL_ONLY
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctlStrobes_t          strobes,
  input  logic [PIN_COUNT-1:0] payload,
  input  logic [SHARED-1:0]    anaMode,
  input  logic [PIN_COUNT-1:0] pinSync,
  output logic [PIN_COUNT-1:0] driveEn,
  output logic [PIN_COUNT-1:0] driveVal,
  output logic [PIN_COUNT-1:0] anaSel,
  output logic [PIN_COUNT-1:0] captureWord,
  output logic                 captureLoad
);

  logic [PIN_COUNT-1:0] dirQ;
  logic [PIN_COUNT-1:0] levelQ;
  logic [PIN_COUNT-1:0] anaSelInt;
  logic [PIN_COUNT-1:0] readMask;

  // Direction register: cleared at reset, 1 = digital output.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirQ <= '0;
    end else if (strobes.loadStatus) begin
      dirQ <= payload;
    end
  end

  // Output-level register keeps its contents through reset.
  always_ff @(posedge clk) begin
    if (strobes.loadOut) begin
      levelQ <= payload;
    end
  end

  // Per-pin mode: digital-only pins never hand over to analog.
  for (genvar p = 0; p < PIN_COUNT; p++) begin : g_pin
    if (p < DIGITAL_ONLY) begin : g_digital
      assign anaSelInt[p] = 1'b0;
    end else begin : g_shared
      assign anaSelInt[p] = anaMode[p-DIGITAL_ONLY] & ~dirQ[p];
    end
  end

  assign readMask = ~(dirQ | anaSelInt);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      captureWord <= '0;
      captureLoad <= 1'b0;
    end else begin
      captureLoad <= strobes.capture;
      if (strobes.capture) begin
        captureWord <= pinSync & readMask;
      end
    end
  end

  assign driveEn  = dirQ;
  assign driveVal = levelQ;
  assign anaSel   = anaSelInt;

endmodule

// File: rtl/pin_expander_top.sv
module pin_expander_top
  import pin_expander_pkg::*;
#(
  parameter int PIN_COUNT    = 12,
  parameter int DIGITAL_ONLY = 4,
  parameter int SYNC_STAGES  = 2,
  localparam int SHARED      = PIN_COUNT - DIGITAL_ONLY
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cmdParWrite,
  input  logic                 cmdStatusWrite,
  input  logic                 cmdCaptureArm,
  input  logic                 csFall,
  input  logic [PIN_COUNT-1:0] payload,
  input  logic [SHARED-1:0]    anaMode,
  input  logic [PIN_COUNT-1:0] pinIn,
  output logic [PIN_COUNT-1:0] driveEn,
  output logic [PIN_COUNT-1:0] driveVal,
  output logic [PIN_COUNT-1:0] anaSel,
  output logic [PIN_COUNT-1:0] captureWord,
  output logic                 captureLoad
);

  ctlStrobes_t          strobes;
  logic [PIN_COUNT-1:0] pinSync;

  pin_expander_sync #(
    .WIDTH (PIN_COUNT),
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk (clk),
    .rstN(rstN),
    .din (pinIn),
    .dout(pinSync)
  );

  pin_expander_ctrl u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .cmdParWrite   (cmdParWrite),
    .cmdStatusWrite(cmdStatusWrite),
    .cmdCaptureArm (cmdCaptureArm),
    .csFall        (csFall),
    .strobes       (strobes)
  );

  pin_expander_dp #(
    .PIN_COUNT   (PIN_COUNT),
    .DIGITAL_ONLY(DIGITAL_ONLY)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .payload    (payload),
    .anaMode    (anaMode),
    .pinSync    (pinSync),
    .driveEn    (driveEn),
    .driveVal   (driveVal),
    .anaSel     (anaSel),
    .captureWord(captureWord),
    .captureLoad(captureLoad)
  );

endmodule

// File: rtl/pin_expander_checker.sv
module pin_expander_checker #(
  parameter int PIN_COUNT    = 12,
  parameter int DIGITAL_ONLY = 4,
  localparam int SHARED      = PIN_COUNT - DIGITAL_ONLY
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 cmdParWrite,
  input logic                 cmdStatusWrite,
  input logic                 csFall,
  input logic [PIN_COUNT-1:0] payload,
  input logic [SHARED-1:0]    anaMode,
  input logic [PIN_COUNT-1:0] driveEn,
  input logic [PIN_COUNT-1:0] driveVal,
  input logic [PIN_COUNT-1:0] anaSel,
  input logic [PIN_COUNT-1:0] captureWord,
  input logic                 captureLoad
);

  assert_exclusive_R4: assert property (@(posedge clk) disable iff (!rstN)
    (driveEn & anaSel) == '0);

  assert_digital_only_R6: assert property (@(posedge clk) disable iff (!rstN)
    anaSel[DIGITAL_ONLY-1:0] == '0);

  assert_flag_gate_R5: assert property (@(posedge clk) disable iff (!rstN)
    (anaSel[PIN_COUNT-1:DIGITAL_ONLY] & ~anaMode) == '0);

  assert_status_load_R3: assert property (@(posedge clk) disable iff (!rstN)
    cmdStatusWrite |=> driveEn == $past(payload));

  assert_level_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    cmdParWrite |=> ((driveVal ^ $past(payload)) & driveEn) == '0);

  assert_capture_origin_R7: assert property (@(posedge clk) disable iff (!rstN)
    captureLoad |-> $past(csFall));

  assert_capture_masked_R8: assert property (@(posedge clk) disable iff (!rstN)
    captureLoad |-> (captureWord & $past(driveEn | anaSel)) == '0);

endmodule

bind pin_expander_top pin_expander_checker #(
  .PIN_COUNT   (PIN_COUNT),
  .DIGITAL_ONLY(DIGITAL_ONLY)
) u_checker (
  .clk           (clk),
  .rstN          (rstN),
  .cmdParWrite   (cmdParWrite),
  .cmdStatusWrite(cmdStatusWrite),
  .csFall        (csFall),
  .payload       (payload),
  .anaMode       (anaMode),
  .driveEn       (driveEn),
  .driveVal      (driveVal),
  .anaSel        (anaSel),
  .captureWord   (captureWord),
  .captureLoad   (captureLoad)
);

// File: tb/pin_expander_top_test.sv
`timescale 1ns/1ps
module pin_expander_top_test;

  localparam int P = 12;
  localparam int D = 4;
  localparam int S = P - D;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         cmdParWrite = 1'b0;
  logic         cmdStatusWrite = 1'b0;
  logic         cmdCaptureArm = 1'b0;
  logic         csFall = 1'b0;
  logic [P-1:0] payload = '0;
  logic [S-1:0] anaMode = '0;
  logic [P-1:0] pinIn = '0;
  logic [P-1:0] driveEn, driveVal, anaSel, captureWord;
  logic         captureLoad;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  pin_expander_top #(.PIN_COUNT(P), .DIGITAL_ONLY(D), .SYNC_STAGES(2)) uut (
    .clk(clk), .rstN(rstN), .cmdParWrite(cmdParWrite),
    .cmdStatusWrite(cmdStatusWrite), .cmdCaptureArm(cmdCaptureArm),
    .csFall(csFall), .payload(payload), .anaMode(anaMode), .pinIn(pinIn),
    .driveEn(driveEn), .driveVal(driveVal), .anaSel(anaSel),
    .captureWord(captureWord), .captureLoad(captureLoad)
  );

  // ---------------- behavioural reference ----------------
  bit [P-1:0] mDir = '0;
  bit [P-1:0] mLevel = '0;
  bit         mLevelKnown = 0;
  bit         mArmed = 0;
  bit [P-1:0] mCap = '0;
  bit         mLoad = 0;
  bit [P-1:0] hist[$];
  bit [P-1:0] oldSync;

  function automatic bit [P-1:0] expAna(bit [S-1:0] am, bit [P-1:0] dir);
    bit [P-1:0] r = '0;
    for (int j = 0; j < S; j++) r[D+j] = am[j] & ~dir[D+j];
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mDir = '0; mArmed = 0; mCap = '0; mLoad = 0;
      hist.delete(); hist.push_back('0); hist.push_back('0);
    end else begin
      oldSync = hist[hist.size()-2];
      mLoad = 0;
      if (csFall && mArmed) begin
        mCap = oldSync & ~(mDir | expAna(anaMode, mDir));
        mLoad = 1;
      end
      if (cmdCaptureArm) mArmed = 1;
      else if (csFall || cmdParWrite || cmdStatusWrite) mArmed = 0;
      if (cmdStatusWrite) mDir = payload;
      hist.push_back(pinIn);
      if (hist.size() > 3) void'(hist.pop_front());
    end
    if (cmdParWrite) begin mLevel = payload; mLevelKnown = 1; end
  end

  task automatic chk(string tag, logic [P-1:0] act, logic [P-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison against the model, away from the active edge.
  always @(negedge clk) begin
    if (rstN && !finished) begin
      chk("R3 driveEn", driveEn, mDir);
      chk("R5 anaSel", anaSel, expAna(anaMode, mDir));
      if (mLevelKnown) chk("R2 driveVal", driveVal & mDir, mLevel & mDir);
      chk("R7 captureWord", captureWord, mCap);
      chk("R9 captureLoad", {11'd0, captureLoad}, {11'd0, mLoad});
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  task automatic writeDir(logic [P-1:0] v);
    payload = v; cmdStatusWrite = 1; tick(); cmdStatusWrite = 0;
  endtask

  task automatic writeLevel(logic [P-1:0] v);
    payload = v; cmdParWrite = 1; tick(); cmdParWrite = 0;
  endtask

  task automatic arm();
    cmdCaptureArm = 1; tick(); cmdCaptureArm = 0;
  endtask

  task automatic fallCs();
    csFall = 1; tick(); csFall = 0;
  endtask

  task automatic finish();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #500000;
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish();
  end

  initial begin
    tick(4);
    chk("R1 driveEn in reset", driveEn, '0);
    chk("R1 anaSel in reset", anaSel, '0);
    chk("R1 captureWord in reset", captureWord, '0);
    rstN = 1; tick(2);
    chk("R1 driveEn after reset", driveEn, '0);
    chk("R1 captureLoad after reset", {11'd0, captureLoad}, '0);

    writeDir(12'hA5C);
    chk("R3 direction load", driveEn, 12'hA5C);
    writeLevel(12'h3F0);
    chk("R2 level on driven pins", driveVal & driveEn, 12'h3F0 & 12'hA5C);

    anaMode = 8'hFF; #1;
    chk("R4 direction overrides analog", anaSel, 12'h5A0);
    chk("R4 exclusive", driveEn & anaSel, '0);
    writeDir(12'h000);
    chk("R5 analog after release", anaSel, 12'hFF0);
    chk("R6 digital-only never analog", {8'd0, anaSel[3:0]}, '0);
    writeDir(12'hFFF);
    anaMode = 8'h0F; tick();
    chk("R4 flag change hidden", anaSel, '0);
    writeDir(12'h000);
    chk("R5 remembered flag returns", anaSel, 12'h0F0);

    writeDir(12'h003); anaMode = 8'h01; pinIn = 12'hFFF; tick(3);
    arm(); tick(); fallCs();
    chk("R7 capture pulse", {11'd0, captureLoad}, 12'd1);
    chk("R8 non-input pins read zero", captureWord, 12'hFEC);
    tick();
    chk("R7 pulse is single", {11'd0, captureLoad}, '0);

    pinIn = 12'h555; tick(3); fallCs();
    chk("R9 unarmed fall no pulse", {11'd0, captureLoad}, '0);
    chk("R9 unarmed fall keeps word", captureWord, 12'hFEC);

    arm(); writeDir(12'h000); fallCs();
    chk("R10 write cancels arm", {11'd0, captureLoad}, '0);

    anaMode = 8'h00; pinIn = 12'hA5A; tick(3);
    arm(); fallCs();
    chk("R7 plain input capture", captureWord, 12'hA5A);

    pinIn = 12'h0F0; tick(3); arm();
    pinIn = 12'h00F; fallCs();
    chk("R7 synchroniser latency", captureWord, 12'h0F0);

    writeLevel(12'h9C3);
    rstN = 0; tick(2);
    chk("R1 reset clears direction", driveEn, '0);
    rstN = 1; tick();
    writeDir(12'hFFF);
    chk("R11 level survives reset", driveVal, 12'h9C3);
    tick(3);
    finish();
  end

endmodule